// File: doc/BRIEF.md
# Routing Upset Logical-Effect Injector

This block sits between two routed nets and the two input pins they normally feed. It imitates, at logic level, what a configuration upset in a routing switch point does to those pins. The first net drives the first pin and the second net drives the second pin. Both nets are `W`-bit buses, and every bit lane is treated the same way.

A test controller describes the fault with three inputs: a physical-damage class, the routing level the switch point belongs to, and a variant bit. It latches them with a one-cycle arm strobe. The block turns the latched class into a logical effect: stuck-at, swap, wired-AND, wired-OR, wired-MIX or pass-through. It then reshapes the pin values combinationally from the live net values.

The selected effect is reported as a code. A separate flag marks classes that the block cannot model. The fault stays fixed between strobes, so a whole test pattern runs against one stable fault.

Top module: `routing_upset_injector`

## Requirements
- R1: After reset the latched class is "none". `effect_code` reads 0 (pass), `unmodelled` is 0, `ci_pin` equals `pi_net` and `dj_pin` equals `pj_net`.
- R2: The class, level and variant inputs are captured at a rising clock edge where `arm` is 1. At every other edge they are ignored and the latched fault is held. `effect_code` and the pins reflect the new fault from just after the capturing edge.
- R3: Stuck-at-0 (effect 1) forces every bit of `ci_pin` to 0. Stuck-at-1 (effect 2) forces every bit of `ci_pin` to 1. In both cases `dj_pin` follows `pj_net`.
- R4: Swap (effect 3) drives `ci_pin` from `pj_net` and `dj_pin` from `pi_net`.
- R5: Wired-AND (effect 4) drives both pins with `pi_net & pj_net`. Wired-OR (effect 5) drives both pins with `pi_net | pj_net`.
- R6: Wired-MIX (effect 6) works per bit. A lane where the two nets agree passes unchanged to both pins. A lane where they disagree gives 1 on `ci_pin` and 0 on `dj_pin`.
- R7: Level codes are 0 = tile, 1 = local, 2 = multi-tile, and 3 behaves as tile. For tile and multi-tile the mapping is as follows. Open (class 1) gives stuck-at-0. Antenna (class 2) gives stuck-at-0. Bridge (class 4) gives swap. Conflict (class 3) gives wired-AND when the variant is 0 and wired-OR when the variant is 1.
- R8: For local routing the mapping is as follows. Open gives stuck-at-1. Antenna gives stuck-at-0. Bridge gives swap. Conflict gives wired-AND when the variant is 0 and wired-MIX when the variant is 1.
- R9: Unrouted (class 5) passes both pins through, reports effect 0 and raises `unmodelled`. None (class 0) and the spare classes 6 and 7 pass through with `unmodelled` low.
- R10: The pins follow any change of `pi_net` or `pj_net` within the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault latch |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Strobe that latches the fault description |
| mod_code | input | 3 | Physical-damage class (0 none, 1 open, 2 antenna, 3 conflict, 4 bridge, 5 unrouted) |
| level_code | input | 2 | Routing level (0 tile, 1 local, 2 multi-tile) |
| variant | input | 1 | Second-effect select for conflict |
| pi_net | input | W | First routed net |
| pj_net | input | W | Second routed net |
| ci_pin | output | W | Pin fed by the first net |
| dj_pin | output | W | Pin fed by the second net |
| effect_code | output | 3 | Selected logical effect |
| unmodelled | output | 1 | Latched class cannot be modelled |

## Verification
Two kinds of timing apply. A fault presented with `arm` high changes `effect_code`, `unmodelled` and the pin behaviour one clock edge later. The bench therefore drives the strobe at a falling edge and samples at the next falling edge, with the capturing rising edge in between.

Net changes reach the pins in the same cycle. The bench applies new net values at a falling edge and samples a couple of nanoseconds later, well before the next rising edge.

Hold behaviour is checked by changing the control inputs with `arm` low across an edge and confirming that the reported effect does not move.

// File: rtl/upset_pkg.sv
package upset_pkg;
  localparam int MOD_W = 3;
  localparam int LVL_W = 2;
  localparam int EFF_W = 3;

  localparam logic [MOD_W-1:0] MOD_NONE     = 3'd0;
  localparam logic [MOD_W-1:0] MOD_OPEN     = 3'd1;
  localparam logic [MOD_W-1:0] MOD_ANTENNA  = 3'd2;
  localparam logic [MOD_W-1:0] MOD_CONFLICT = 3'd3;
  localparam logic [MOD_W-1:0] MOD_BRIDGE   = 3'd4;
  localparam logic [MOD_W-1:0] MOD_UNROUTED = 3'd5;

  localparam logic [LVL_W-1:0] LVL_TILE  = 2'd0;
  localparam logic [LVL_W-1:0] LVL_LOCAL = 2'd1;
  localparam logic [LVL_W-1:0] LVL_MULTI = 2'd2;

  localparam logic [EFF_W-1:0] EFF_PASS = 3'd0;
  localparam logic [EFF_W-1:0] EFF_SA0  = 3'd1;
  localparam logic [EFF_W-1:0] EFF_SA1  = 3'd2;
  localparam logic [EFF_W-1:0] EFF_SWAP = 3'd3;
  localparam logic [EFF_W-1:0] EFF_WAND = 3'd4;
  localparam logic [EFF_W-1:0] EFF_WOR  = 3'd5;
  localparam logic [EFF_W-1:0] EFF_WMIX = 3'd6;

  typedef struct packed {
    logic [MOD_W-1:0] cls;
    logic [LVL_W-1:0] lvl;
    logic             alt;
  } fault_ctl_t;

  // Physical class plus routing level -> logical effect
  function automatic logic [EFF_W-1:0] map_effect(input fault_ctl_t f);
    logic is_local;
    is_local = (f.lvl == LVL_LOCAL);
    case (f.cls)
      MOD_OPEN:     map_effect = is_local ? EFF_SA1 : EFF_SA0;
      MOD_ANTENNA:  map_effect = EFF_SA0;
      MOD_BRIDGE:   map_effect = EFF_SWAP;
      MOD_CONFLICT: begin
        if (!f.alt)        map_effect = EFF_WAND;
        else if (is_local) map_effect = EFF_WMIX;
        else               map_effect = EFF_WOR;
      end
      default:      map_effect = EFF_PASS;
    endcase
  endfunction
endpackage

// File: rtl/upset_ctl_reg.sv
module upset_ctl_reg
  import upset_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  fault_ctl_t ctl_in,
  output fault_ctl_t ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{cls: MOD_NONE, lvl: LVL_TILE, alt: 1'b0};
    end else if (arm) begin
      ctl_q <= ctl_in;
    end
  end
endmodule

// File: rtl/upset_effect_map.sv
module upset_effect_map
  import upset_pkg::*;
(
  input  fault_ctl_t       ctl,
  output logic [EFF_W-1:0] effect,
  output logic             unmodelled
);
  always_comb begin
    effect     = map_effect(ctl);
    unmodelled = (ctl.cls == MOD_UNROUTED);
  end
endmodule

// File: rtl/upset_pin_drive.sv
module upset_pin_drive
  import upset_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [EFF_W-1:0] effect,
  input  logic [W-1:0]     pi_net,
  input  logic [W-1:0]     pj_net,
  output logic [W-1:0]     ci_pin,
  output logic [W-1:0]     dj_pin
);
  logic [W-1:0] lane_differs;
  assign lane_differs = pi_net ^ pj_net;

  for (genvar b = 0; b < W; b++) begin : g_lane
    always_comb begin
      ci_pin[b] = pi_net[b];
      dj_pin[b] = pj_net[b];
      case (effect)
        EFF_SA0:  ci_pin[b] = 1'b0;
        EFF_SA1:  ci_pin[b] = 1'b1;
        EFF_SWAP: begin
          ci_pin[b] = pj_net[b];
          dj_pin[b] = pi_net[b];
        end
        EFF_WAND: begin
          ci_pin[b] = pi_net[b] && pj_net[b];
          dj_pin[b] = pi_net[b] && pj_net[b];
        end
        EFF_WOR: begin
          ci_pin[b] = pi_net[b] || pj_net[b];
          dj_pin[b] = pi_net[b] || pj_net[b];
        end
        EFF_WMIX: begin
          if (lane_differs[b]) begin
            ci_pin[b] = 1'b1;
            dj_pin[b] = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/routing_upset_injector.sv
module routing_upset_injector
  import upset_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [2:0]       mod_code,
  input  logic [1:0]       level_code,
  input  logic             variant,
  input  logic [W-1:0]     pi_net,
  input  logic [W-1:0]     pj_net,
  output logic [W-1:0]     ci_pin,
  output logic [W-1:0]     dj_pin,
  output logic [2:0]       effect_code,
  output logic             unmodelled
);
  fault_ctl_t ctl_in, ctl_q;
  assign ctl_in = '{cls: mod_code, lvl: level_code, alt: variant};

  upset_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .ctl_in(ctl_in), .ctl_q(ctl_q)
  );

  upset_effect_map u_map (
    .ctl(ctl_q), .effect(effect_code), .unmodelled(unmodelled)
  );

  upset_pin_drive #(.W(W)) u_pins (
    .effect(effect_code), .pi_net(pi_net), .pj_net(pj_net),
    .ci_pin(ci_pin), .dj_pin(dj_pin)
  );

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(effect_code) && $stable(unmodelled));
  assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> unmodelled == ($past(mod_code) == MOD_UNROUTED));
  assert_stuck_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (effect_code == EFF_SA0 || effect_code == EFF_SA1) |->
      dj_pin == pj_net && ci_pin == {W{effect_code == EFF_SA1}});
  assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    effect_code == EFF_SWAP |-> ci_pin == pj_net && dj_pin == pi_net);
  assert_wired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (effect_code == EFF_WAND || effect_code == EFF_WOR) |-> ci_pin == dj_pin);
  assert_mix_R6: assert property (@(posedge clk) disable iff (!rst_n)
    effect_code == EFF_WMIX |-> ci_pin == (pi_net | pj_net) && dj_pin == (pi_net & pj_net));
  assert_flag_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unmodelled |-> effect_code == EFF_PASS && ci_pin == pi_net && dj_pin == pj_net);
endmodule

// File: tb/sim_routing_upset_injector.sv
module sim_routing_upset_injector;
  localparam int W = 4;
  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, variant = 1'b0;
  logic [2:0] mod_code = 3'd0;
  logic [1:0] level_code = 2'd0;
  logic [W-1:0] pi_net = '0, pj_net = '0, ci_pin, dj_pin;
  logic [2:0] effect_code;
  logic unmodelled;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  routing_upset_injector #(.W(W)) u0 (.*);

  function automatic logic [2:0] want_effect(logic [2:0] m, logic [1:0] l, logic v);
    bit loc = (l == 2'd1);
    if (m == 3'd1) return loc ? 3'd2 : 3'd1;
    if (m == 3'd2) return 3'd1;
    if (m == 3'd4) return 3'd3;
    if (m == 3'd3) return v ? (loc ? 3'd6 : 3'd5) : 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [2*W-1:0] want_pins(logic [2:0] e, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] c, d;
    for (int k = 0; k < W; k++) begin
      c[k] = a[k]; d[k] = b[k];
      if (e == 3'd1) c[k] = 0;
      else if (e == 3'd2) c[k] = 1;
      else if (e == 3'd3) begin c[k] = b[k]; d[k] = a[k]; end
      else if (e == 3'd4) begin c[k] = a[k] & b[k]; d[k] = c[k]; end
      else if (e == 3'd5) begin c[k] = a[k] | b[k]; d[k] = c[k]; end
      else if (e == 3'd6 && a[k] != b[k]) begin c[k] = 1; d[k] = 0; end
    end
    return {c, d};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(logic [2:0] m, logic [1:0] l, logic v);
    @(negedge clk);
    mod_code = m; level_code = l; variant = v; arm = 1;
    @(negedge clk);
    arm = 0;
  endtask

  task automatic pins_check(string req, logic [2:0] e);
    logic [2*W-1:0] x;
    #2;
    x = want_pins(e, pi_net, pj_net);
    chk(req, {ci_pin, dj_pin}, x);
  endtask

  task automatic fault_check(string req, logic [2:0] m, logic [1:0] l, logic v);
    logic [2:0] e;
    load(m, l, v);
    e = want_effect(m, l, v);
    chk(req, effect_code, e);
    chk(req, unmodelled, m == 3'd5);
    for (int i = 0; i < 4; i++) begin
      pi_net = W'($urandom); pj_net = W'($urandom);
      pins_check(req, e);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    pi_net = 4'hA; pj_net = 4'h6;
    #5;
    chk("R1 effect", effect_code, 0);
    chk("R1 flag", unmodelled, 0);
    chk("R1 pins", {ci_pin, dj_pin}, {4'hA, 4'h6});
    @(negedge clk); rst_n = 1;

    fault_check("R7 tile open", 3'd1, 2'd0, 0);
    fault_check("R7 multi antenna", 3'd2, 2'd2, 1);
    fault_check("R7 tile conflict and", 3'd3, 2'd0, 0);
    fault_check("R7 multi conflict or", 3'd3, 2'd2, 1);
    fault_check("R7 level3 conflict or", 3'd3, 2'd3, 1);
    fault_check("R8 local open", 3'd2 - 3'd1, 2'd1, 0);
    fault_check("R8 local antenna", 3'd2, 2'd1, 0);
    fault_check("R8 local conflict mix", 3'd3, 2'd1, 1);
    fault_check("R8 local bridge", 3'd4, 2'd1, 0);
    fault_check("R4 bridge", 3'd4, 2'd0, 1);
    fault_check("R9 unrouted", 3'd5, 2'd1, 1);
    fault_check("R9 spare", 3'd7, 2'd1, 1);

    // R3 stuck-at with all-ones / all-zeros nets
    load(3'd1, 2'd0, 0);
    pi_net = 4'hF; pj_net = 4'h5; pins_check("R3 sa0", 3'd1);
    load(3'd1, 2'd1, 0);
    pi_net = 4'h0; pj_net = 4'h9; pins_check("R3 sa1", 3'd2);
    // R5 directed
    load(3'd3, 2'd2, 0);
    pi_net = 4'hC; pj_net = 4'hA; pins_check("R5 and", 3'd4);
    load(3'd3, 2'd0, 1);
    pins_check("R5 or", 3'd5);
    // R6 all lanes equal then all differ
    load(3'd3, 2'd1, 1);
    pi_net = 4'h3; pj_net = 4'h3; pins_check("R6 equal", 3'd6);
    pi_net = 4'h5; pj_net = 4'hA; pins_check("R6 differ", 3'd6);
    // R10 same-cycle follow
    pi_net = 4'h1; pj_net = 4'h1; pins_check("R10 follow", 3'd6);

    // R2 hold: inputs move without arm
    @(negedge clk);
    mod_code = 3'd4; level_code = 2'd0; variant = 0;
    @(negedge clk); @(negedge clk);
    chk("R2 hold", effect_code, 3'd6);

    for (int n = 0; n < 300; n++) begin
      logic [2:0] m; logic [1:0] l; logic v;
      m = 3'($urandom); l = 2'($urandom); v = 1'($urandom);
      fault_check("R7/R8 random", m, l, v);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule